// File: doc/BRIEF.md
# Retransmit FIFO Buffer

This block is a single-clock first-in/first-out store of 9-bit words. Eight data bits and one parity or control bit travel together. Circular write and read pointers address an internal array, so the user supplies no address. Writing and reading are single-cycle enables sampled on the rising clock edge. The read word appears on a registered output port one cycle after an accepted read. Three status flags report the fill level: empty, full, and more than half full.

A retransmit request rewinds the read pointer to location zero, so the stored data can be read again from the beginning. This is intended for frames no longer than the depth. The buffer also passes data straight through at its two limits:

- **Empty:** a read held on an empty buffer receives the word written in that same cycle.
- **Full:** a write held on a full buffer lands in the slot freed by the read in that same cycle.

Depth is a parameter and must be a power of two, at least 4. The reset is synchronous and active low.

Top module: `rt_fifo`

## Requirements
- R1: Words leave `rd_data` in the order in which they were accepted, with all 9 bits intact. No address input exists.
- R2: After a clock edge with `rst_n` low, the outputs are: `empty`=1, `full`=0, `half_full`=0, `rd_data`=0. Both pointers are at location 0.
- R3: With an occupancy strictly between 0 and DEPTH, a cycle with both `wr_en` and `rd_en` stores one word and delivers one word. The occupancy does not change.
- R4: A write on a full buffer without a read in the same cycle is ignored and stores nothing. The next read clears `full`.
- R5: A read on an empty buffer without a write in the same cycle does not move the read pointer or change `rd_data`.
- R6: The flags are driven from the stored-word count:
  - `empty` is 1 exactly when the count is 0.
  - `full` is 1 exactly when the count equals DEPTH.
  - `half_full` is 1 exactly when the count is greater than DEPTH/2.
- R7: A cycle with `rewind_n` low has these effects:
  - The read pointer moves to location 0.
  - The count becomes the write pointer's location index. If that index is 0, the count becomes DEPTH when the write pointer has wrapped an odd number of times, and 0 otherwise.
  - `wr_en` and `rd_en` are ignored in that cycle, and `rd_data` holds its value.
- R8: Read flow-through. On an empty buffer, a cycle with both `wr_en` and `rd_en` puts `wr_data` on `rd_data` at the next edge and keeps `empty` at 1. The word is still written into the array.
- R9: Write flow-through. On a full buffer, a cycle with both `wr_en` and `rd_en` delivers the oldest word and stores the new one. `full` stays at 1.
- R10: `rd_data` changes only on an accepted read. It holds its value through idle, write-only and ignored-read cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | WIDTH (9) | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rewind_n | input | 1 | Retransmit request, active low: rewinds the read pointer |
| rd_data | output | WIDTH (9) | Last word read, registered |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
The bench fills an 8-deep instance to every occupancy from 0 to 8. At each level it applies idle, write-only, read-only and combined cycles, then drains the buffer and compares every word and flag against an arithmetic model.

- At occupancy 0 and 8, the combined cycle separates the flow-through paths from ignored requests.
- At the interior levels, the combined cycle shows that the count holds.
- Draining after a write on a full buffer shows whether a rejected word slipped into the array.

Separate retransmit runs cover three cases:
- a partial frame, including a flowed-through word;
- a frame of exactly DEPTH words, which must rewind to full;
- a write pointer that has passed location zero once.

Together these show the rewound count and the replayed data.

// File: rtl/rt_fifo_pkg.sv
// Package: shared definitions for the retransmit FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rt_fifo_pkg;

    // Operation selected for a cycle by the controller.
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_BOTH   = 3'd3,
        OP_REWIND = 3'd4
    } fifo_op_e;

endpackage

// File: rtl/rt_fifo_ctrl.sv
// Module: rt_fifo_ctrl
// Decides each cycle whether a write, a read, both, or a rewind takes place.
// Keeps the write and read location indices, the write wrap bit and the
// stored-word count, and derives the three status flags from that count.
// Assumes: DEPTH is a power of two and at least 4; the reset is synchronous
// and active low.
module rt_fifo_ctrl
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic                       rewind_n,
    output logic                       wr_do,
    output logic                       rd_do,
    output logic                       bypass,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic                       empty,
    output logic                       full,
    output logic                       half_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

    logic [AW-1:0] wr_idx_q, rd_idx_q;
    logic          wrap_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] rewind_cnt;
    logic          wr_ok, rd_ok;
    fifo_op_e      op;

    // Derive the status flags from the registered count.
    always_comb begin
        empty     = (count_q == '0);
        full      = (count_q == CNT_FULL);
        half_full = (count_q > CNT_HALF);
    end

    // Accept requests, allowing flow-through at both the empty and the full limit.
    always_comb begin
        wr_ok = wr_en && (!full || rd_en);
        rd_ok = rd_en && (!empty || wr_en);
        if (!rewind_n)          op = OP_REWIND;
        else if (wr_ok && rd_ok) op = OP_BOTH;
        else if (wr_ok)          op = OP_PUSH;
        else if (rd_ok)          op = OP_POP;
        else                     op = OP_IDLE;
    end

    // Compute the count that a rewind produces from the write position.
    always_comb begin
        if (wr_idx_q == '0) rewind_cnt = wrap_q ? CNT_FULL : '0;
        else                rewind_cnt = {1'b0, wr_idx_q};
    end

    // Drive the strobes for the storage array.
    always_comb begin
        wr_do  = (op == OP_PUSH) || (op == OP_BOTH);
        rd_do  = (op == OP_POP)  || (op == OP_BOTH);
        bypass = (op == OP_BOTH) && empty;
    end

    assign wr_idx = wr_idx_q;
    assign rd_idx = rd_idx_q;

    // Advance the pointers and the count according to the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            wrap_q   <= 1'b0;
            count_q  <= '0;
        end else begin
            if (wr_do) begin
                wr_idx_q <= wr_idx_q + 1'b1;
                if (wr_idx_q == '1) wrap_q <= ~wrap_q;
            end
            if (op == OP_REWIND)  rd_idx_q <= '0;
            else if (rd_do)       rd_idx_q <= rd_idx_q + 1'b1;
            case (op)
                OP_PUSH:   count_q <= count_q + 1'b1;
                OP_POP:    count_q <= count_q - 1'b1;
                OP_REWIND: count_q <= rewind_cnt;
                default:   count_q <= count_q;
            endcase
        end
    end

    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_idx_q == '0 && wr_idx_q == '0 && empty));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BOTH) |=> (count_q == $past(count_q)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_n && full && wr_en && !rd_en) |=> ($stable(wr_idx_q) && full));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_n && empty && rd_en && !wr_en) |=> ($stable(rd_idx_q) && empty));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q <= CNT_FULL) && !(empty && full));

    // R7
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> (rd_idx_q == '0 && $stable(wr_idx_q)));

endmodule

// File: rtl/rt_fifo_mem.sv
// Module: rt_fifo_mem
// Storage array with one write port and a registered read port. On a
// flow-through read, the word being written goes straight to the output.
// Assumes: at most one write and one read per cycle; a read of the slot being
// written returns the old contents unless bypass is set.
module rt_fifo_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_do,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic                      rd_do,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    input  logic                      bypass,
    output logic [WIDTH-1:0]          rd_data
);
    logic [WIDTH-1:0] store [DEPTH];

    // Write the incoming word into its slot.
    always_ff @(posedge clk) begin
        if (wr_do) store[wr_idx] <= wr_data;
    end

    // Register the read word, taking the incoming word on flow-through.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_do)  rd_data <= bypass ? wr_data : store[rd_idx];
    end

    // R8
    flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_do && bypass) |=> (rd_data == $past(wr_data)));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_do |=> $stable(rd_data));

endmodule

// File: rtl/rt_fifo.sv
// Module: rt_fifo (top)
// Single-clock FIFO of WIDTH-bit words with a retransmit rewind and
// empty/full/half-full flags. Connects the controller to the storage array.
// Assumes: DEPTH is a power of two and at least 4; wr_en and rd_en are low
// while reset is released.
module rt_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             half_full
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_do, rd_do, bypass;
    logic [AW-1:0] wr_idx, rd_idx;

    rt_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rewind_n  (rewind_n),
        .wr_do     (wr_do),
        .rd_do     (rd_do),
        .bypass    (bypass),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    rt_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_do   (wr_do),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_do   (rd_do),
        .rd_idx  (rd_idx),
        .bypass  (bypass),
        .rd_data (rd_data)
    );

    // R9
    flow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_n && full && wr_en && rd_en) |=> full);

endmodule

// File: tb/rt_fifo_tb_top.sv
// Bench: sweeps an 8-deep FIFO over every occupancy and every request mix,
// plus retransmit cases, against an arithmetic model.
module rt_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WIDTH = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic             rewind_n = 1'b1;
    logic [WIDTH-1:0] rd_data;
    logic             empty, full, half_full;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    int m_q [DEPTH];
    int m_wr = 0, m_rd = 0, m_cnt = 0, m_out = 0;
    bit m_wrap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind_n(rewind_n), .rd_data(rd_data),
        .empty(empty), .full(full), .half_full(half_full)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk("R6", "empty",     int'(empty),     int'(m_cnt == 0));
        chk("R6", "full",      int'(full),      int'(m_cnt == DEPTH));
        chk("R6", "half_full", int'(half_full), int'(m_cnt > DEPTH/2));
        chk(req,  "rd_data",   int'(rd_data),   m_out);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1; wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_wr = 0; m_rd = 0; m_cnt = 0; m_out = 0; m_wrap = 1'b0;
        // R2: reset state
        chk("R2", "empty", int'(empty), 1);
        chk("R2", "full", int'(full), 0);
        chk("R2", "half_full", int'(half_full), 0);
        chk("R2", "rd_data", int'(rd_data), 0);
    endtask

    // One cycle: drive at the falling edge, predict, check after the rising edge.
    task automatic cyc(input bit w, input int d, input bit r, input bit rw, input string req);
        bit wok, rok;
        @(negedge clk);
        wr_en = w; wr_data = WIDTH'(d); rd_en = r; rewind_n = !rw;
        if (rw) begin
            m_rd = 0;
            m_cnt = (m_wr == 0) ? (m_wrap ? DEPTH : 0) : m_wr;
        end else begin
            wok = w && (m_cnt < DEPTH || r);
            rok = r && (m_cnt > 0 || w);
            if (rok) begin
                m_out = (m_cnt == 0) ? (d % (1 << WIDTH)) : m_q[m_rd];
                m_rd = (m_rd + 1) % DEPTH;
            end
            if (wok) begin
                m_q[m_wr] = d % (1 << WIDTH);
                if (m_wr == DEPTH-1) m_wrap = ~m_wrap;
                m_wr = (m_wr + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(wok) - int'(rok);
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_state(req);
    endtask

    task automatic drain(input string req);
        while (m_cnt > 0) cyc(1'b0, 0, 1'b1, 1'b0, req);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Sweep every start occupancy and every request mix.
        for (int k = 0; k <= DEPTH; k++) begin
            for (int c = 0; c < 4; c++) begin
                string tag;
                do_reset();
                for (int i = 0; i < k; i++)
                    cyc(1'b1, 300 + k*13 + i*7, 1'b0, 1'b0, "R1");
                if (c == 3)      tag = (k == 0) ? "R8" : ((k == DEPTH) ? "R9" : "R3");
                else if (c == 1) tag = (k == DEPTH) ? "R4" : "R1";
                else if (c == 2) tag = (k == 0) ? "R5" : "R10";
                else             tag = "R10";
                cyc(c[0], 100 + k*5 + c, c[1], 1'b0, tag);
                // Second ignored read on empty must stay ignored (R5).
                if (c == 2 && k == 0) cyc(1'b0, 0, 1'b1, 1'b0, "R5");
                drain("R1");
            end
        end

        // R7: partial frame including a flowed-through first word, then replay.
        do_reset();
        cyc(1'b1, 9'h1A5, 1'b1, 1'b0, "R8");
        cyc(1'b1, 9'h0F0, 1'b0, 1'b0, "R1");
        cyc(1'b1, 9'h10F, 1'b0, 1'b0, "R1");
        cyc(1'b1, 9'h055, 1'b0, 1'b0, "R1");
        cyc(1'b0, 0, 1'b1, 1'b0, "R1");
        cyc(1'b1, 9'h077, 1'b1, 1'b1, "R7");
        drain("R7");

        // R7: exactly DEPTH words written, rewind must give a full buffer.
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 9'h100 + i*3, 1'b0, 1'b0, "R1");
        cyc(1'b0, 0, 1'b1, 1'b0, "R1");
        cyc(1'b0, 0, 1'b1, 1'b0, "R1");
        cyc(1'b0, 0, 1'b0, 1'b1, "R7");
        drain("R7");

        // R7: write pointer past location zero once, then rewind.
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 40 + i, 1'b0, 1'b0, "R1");
        drain("R1");
        for (int i = 0; i < 3; i++) cyc(1'b1, 200 + i, 1'b0, 1'b0, "R1");
        cyc(1'b0, 0, 1'b0, 1'b1, "R7");
        drain("R7");

        // R7: rewind on a fresh buffer leaves it empty.
        do_reset();
        cyc(1'b0, 0, 1'b0, 1'b1, "R7");

        finish_run();
    end
endmodule